// File: doc/BRIEF.md
# Serial Tuner Synthesiser Control Port

This block is a two-wire serial slave that holds the programming state of a frequency synthesiser. A bus master writes data bytes that the block sorts into two kinds of byte pairs by their leading bit. A pair with leading 0 carries the low fifteen bits of the 17-bit loop divide ratio. A pair with leading 1 carries the two top ratio bits, the prescaler enable, the reference divider select, the charge pump current, the reference output controls and four port levels. Pairs may follow each other without a new address until the master ends the transfer.

The divide ratio the loop uses changes only in two cases: when all seventeen bits have arrived in one transfer, or when a STOP ends a transfer that delivered at least one whole data byte. Sending frequency pairs on their own over and over therefore never moves the loop in the middle of a transfer, which keeps fine tuning free of glitches. In read mode the block returns a status byte holding a power-up flag, the loop lock flag and a 3-bit converter code. It keeps sending that byte for as long as the master acknowledges it.

SCL and SDA are oversampled by the block clock. The block drives SDA only through an open-drain enable.

Top module: `tuner_i2c_ctrl`

## Requirements
- R1: The address byte, sent MSB first, is 1,1,0,0,0,sel[1],sel[0],rw (rw=0 write, rw=1 read). On a match the block pulls SDA low for the ninth clock. On any other address it does not acknowledge and ignores the rest of the transfer.
- R2: In a write transfer every complete data byte is acknowledged by pulling SDA low for its ninth clock.
- R3: The first byte of a pair with bit 7 = 0 loads ratio bits 14..8 from its bits 6..0. The second byte of that pair loads ratio bits 7..0.
- R4: The first byte of a pair with bit 7 = 1 loads ratio bits 16..15 from its bits 6..5, prescaler enable from bit 4 and the reference divider select from bits 3..0; these control fields take effect at once. The second byte gives charge pump current (bits 7..6), reference output enable (bit 5), reference output source (bit 4) and port levels 3..0 (bits 3..0).
- R5: `div_word` takes the staged ratio as soon as both frequency bytes and the first control byte have arrived in one transfer, or at a STOP after one or more complete data bytes. Frequency pairs alone, without STOP, leave it unchanged.
- R6: Pairs repeat without readdressing, and each pair is classified again by bit 7 of its first byte. A START restarts the pairing.
- R7: A STOP inside a byte discards the partial byte and keeps all earlier values.
- R8: A read returns {por, lock, 0, 0, 0, adc[2:0]} MSB first, refreshed for each byte while the master acknowledges. After a not-acknowledge the block leaves SDA released until the next START.
- R9: The power-up flag is 1 after reset and is cleared by a STOP that ends a read transfer. `port_hiz` follows the flag.
- R10: A second control byte with bit 5 = 0 and bit 4 = 1 puts its bits 2..0 into `test_sel` and leaves port levels 2..0 unchanged. Port level 3 is still updated.
- R11: After reset the reference output enable and source are 1 and every other register is 0.
- R12: The block changes its SDA enable only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_sel | input | 2 | Low two address bits |
| lock_in | input | 1 | Loop lock flag for the status byte |
| adc_code | input | 3 | Converter code for the status byte |
| sda_oe | output | 1 | 1 pulls SDA low |
| div_word | output | 17 | Active loop divide ratio |
| presc_en | output | 1 | Divide-by-two prescaler enable |
| ref_div_sel | output | 4 | Reference divider select |
| cp_cur | output | 2 | Charge pump current select |
| ref_out_en | output | 1 | Reference output enable |
| ref_out_cmp | output | 1 | Reference output source / test enable |
| port_out | output | 4 | Port output levels |
| port_hiz | output | 1 | Ports held high-impedance |
| test_sel | output | 3 | Test mode select |

## Verification
The bench sends frequency pairs repeatedly without STOP and samples `div_word` before the STOP. A design that commits on every low frequency byte would move the ratio there. It sends the pairs in both orders and checks the ratio right after the byte that completes all seventeen bits. A design that waits for STOP, or that classifies only the first pair, would show a stale ratio. It ends a transfer with a STOP in the middle of a byte whose bits would look like a control byte; a design that accepts partial bytes would change the reference select. It also reads past a not-acknowledge, where a design that keeps driving would return zeros instead of a released line. Finally it checks the power-up flag before and after a read is closed by STOP.

// File: rtl/tuner_pkg.sv
// Shared constants and types for the tuner control port.
package tuner_pkg;
    localparam int DIV_W     = 17;          // loop divide ratio width
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam logic [4:0] ADDR_FIXED = 5'b11000;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
    } bus_state_t;
endpackage

// File: rtl/tuner_line_sync.sv
// Line synchroniser: brings SCL/SDA into the clock domain through STAGES
// flops and flags clock edges, START and STOP.
// Assumes the bus is far slower than clk (several clocks per SCL phase).
module tuner_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sr, sda_sr;
    logic scl_q, sda_q;

    // synchronise both lines, idle-high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_in};
            sda_sr <= {sda_sr[STAGES-2:0], sda_in};
            scl_q  <= scl_sr[STAGES-1];
            sda_q  <= sda_sr[STAGES-1];
        end
    end

    assign scl_s = scl_sr[STAGES-1];
    assign sda_s = sda_sr[STAGES-1];

    // edge and condition decode
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/tuner_bus_engine.sv
// Bit-level slave engine: matches the address, shifts write bytes in,
// acknowledges them, and shifts the status byte out in read mode.
// Assumes events from tuner_line_sync; never drives SDA with SCL high.
module tuner_bus_engine
    import tuner_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        addr_sel,
    input  logic [BYTE_W-1:0] status,
    output logic              sda_oe,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              rd_hit
);
    bus_state_t        state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              mack;

    assign byte_data = shreg;

    // bus protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            sda_oe     <= 1'b0;
            byte_valid <= 1'b0;
            rd_hit     <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            rd_hit     <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == CNT_W'(BYTE_W)) begin
                            bitcnt <= '0;
                            if (state == ST_WR) begin
                                byte_valid <= 1'b1;
                                sda_oe     <= 1'b1;
                                state      <= ST_WR_ACK;
                            end else if (shreg[7:1] == {ADDR_FIXED, addr_sel}) begin
                                rw     <= shreg[0];
                                rd_hit <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg  <= status;
                                sda_oe <= ~status[BYTE_W-1];
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt == CNT_W'(BYTE_W)) begin
                                bitcnt <= '0;
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                shreg  <= status;
                                sda_oe <= ~status[BYTE_W-1];
                                state  <= ST_RD;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R12: the enable only rises in the low phase of SCL
    a_r12_oe_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R8: after a not-acknowledge the line is released
    a_r8_release_on_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_fall && !mack && !start_det && !stop_det) |=> !sda_oe);

    // R1: an address acknowledge is only entered from a full address byte
    a_r1_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bitcnt != CNT_W'(BYTE_W)) |=> !sda_oe);
endmodule

// File: rtl/tuner_reg_file.sv
// Register file: steers received bytes into frequency or control pairs,
// stages the divide ratio and commits it on a full word or at STOP,
// and builds the status byte with the power-up flag.
module tuner_reg_file
    import tuner_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              rd_hit,
    input  logic              lock_in,
    input  logic [2:0]        adc_code,
    output logic [BYTE_W-1:0] status,
    output logic [DIV_W-1:0]  div_word,
    output logic              presc_en,
    output logic [3:0]        ref_div_sel,
    output logic [1:0]        cp_cur,
    output logic              ref_out_en,
    output logic              ref_out_cmp,
    output logic [3:0]        port_out,
    output logic              port_hiz,
    output logic [2:0]        test_sel
);
    logic [DIV_W-1:0] stage, stage_n;
    logic got_hi, got_lo, got_ca, hi_n, lo_n, ca_n;
    logic second, pair_ctl, rd_txn, por;
    logic full_word;

    // next staged ratio and arrival flags for the byte now presented
    always_comb begin
        stage_n = stage;
        hi_n    = got_hi;
        lo_n    = got_lo;
        ca_n    = got_ca;
        if (byte_valid) begin
            if (!second) begin
                if (!byte_data[7]) begin
                    stage_n[14:8] = byte_data[6:0];
                    hi_n          = 1'b1;
                end else begin
                    stage_n[16:15] = byte_data[6:5];
                    ca_n           = 1'b1;
                end
            end else if (!pair_ctl) begin
                stage_n[7:0] = byte_data;
                lo_n         = 1'b1;
            end
        end
        full_word = hi_n & lo_n & ca_n;
    end

    // register updates, pair tracking and commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0; div_word <= '0;
            got_hi <= 1'b0; got_lo <= 1'b0; got_ca <= 1'b0;
            second <= 1'b0; pair_ctl <= 1'b0; rd_txn <= 1'b0; por <= 1'b1;
            presc_en <= 1'b0; ref_div_sel <= '0; cp_cur <= '0;
            ref_out_en <= 1'b1; ref_out_cmp <= 1'b1;
            port_out <= '0; test_sel <= '0;
        end else if (start_det) begin
            second <= 1'b0;
            got_hi <= 1'b0; got_lo <= 1'b0; got_ca <= 1'b0;
            rd_txn <= 1'b0;
        end else if (stop_det) begin
            if (got_hi | got_lo | got_ca) div_word <= stage;
            got_hi <= 1'b0; got_lo <= 1'b0; got_ca <= 1'b0;
            second <= 1'b0;
            if (rd_txn) por <= 1'b0;
            rd_txn <= 1'b0;
        end else begin
            if (rd_hit) rd_txn <= 1'b1;
            stage <= stage_n;
            if (byte_valid) begin
                second <= ~second;
                if (!second) pair_ctl <= byte_data[7];
                if (!second && byte_data[7]) begin
                    presc_en    <= byte_data[4];
                    ref_div_sel <= byte_data[3:0];
                end
                if (second && pair_ctl) begin
                    cp_cur      <= byte_data[7:6];
                    ref_out_en  <= byte_data[5];
                    ref_out_cmp <= byte_data[4];
                    port_out[3] <= byte_data[3];
                    if (!byte_data[5] && byte_data[4]) test_sel <= byte_data[2:0];
                    else port_out[2:0] <= byte_data[2:0];
                end
            end
            if (full_word) begin
                div_word <= stage_n;
                got_hi <= 1'b0; got_lo <= 1'b0; got_ca <= 1'b0;
            end else begin
                got_hi <= hi_n; got_lo <= lo_n; got_ca <= ca_n;
            end
        end
    end

    assign status   = {por, lock_in, 3'b000, adc_code};
    assign port_hiz = por;

    // R5: the active ratio moves only on a received byte or a STOP
    a_r5_ratio_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_word) |-> $past(byte_valid || stop_det));

    // R9: the power-up flag only clears at a STOP
    a_r9_por_clear_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por) |-> $past(stop_det));

    // R10: low port levels hold across a test-select byte
    a_r10_ports_hold_test: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && second && pair_ctl && !byte_data[5] && byte_data[4]
         && !start_det && !stop_det) |=> $stable(port_out[2:0]));

    // R9: power-up flag never sets again once cleared
    a_r9_por_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(por));
endmodule

// File: rtl/tuner_i2c_ctrl.sv
// Top of the tuner control port: line synchroniser, bus engine and
// register file. Assumes clk oversamples SCL by several cycles per phase.
module tuner_i2c_ctrl
    import tuner_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [1:0]       addr_sel,
    input  logic             lock_in,
    input  logic [2:0]       adc_code,
    output logic             sda_oe,
    output logic [DIV_W-1:0] div_word,
    output logic             presc_en,
    output logic [3:0]       ref_div_sel,
    output logic [1:0]       cp_cur,
    output logic             ref_out_en,
    output logic             ref_out_cmp,
    output logic [3:0]       port_out,
    output logic             port_hiz,
    output logic [2:0]       test_sel
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic byte_valid, rd_hit;
    logic [BYTE_W-1:0] byte_data, status;

    tuner_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tuner_bus_engine u_eng (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .addr_sel(addr_sel), .status(status), .sda_oe(sda_oe),
        .byte_valid(byte_valid), .byte_data(byte_data), .rd_hit(rd_hit)
    );

    tuner_reg_file u_regs (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .start_det(start_det), .stop_det(stop_det), .rd_hit(rd_hit),
        .lock_in(lock_in), .adc_code(adc_code), .status(status),
        .div_word(div_word), .presc_en(presc_en), .ref_div_sel(ref_div_sel),
        .cp_cur(cp_cur), .ref_out_en(ref_out_en), .ref_out_cmp(ref_out_cmp),
        .port_out(port_out), .port_hiz(port_hiz), .test_sel(test_sel)
    );
endmodule

// File: tb/sim_tuner_i2c_ctrl.sv
// Directed bench: a bus master model drives the open-drain lines and each
// scenario task checks its own results at the ports.
module sim_tuner_i2c_ctrl;
    localparam int Q = 10;            // clocks per quarter bus bit
    localparam logic [7:0] WADDR = 8'hC4, RADDR = 8'hC5, BADADDR = 8'hC2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b10;
    logic lock_in = 1'b0;
    logic [2:0] adc_code = 3'b000;
    logic sda_oe, presc_en, ref_out_en, ref_out_cmp, port_hiz;
    logic [16:0] div_word;
    logic [3:0] ref_div_sel, port_out;
    logic [1:0] cp_cur;
    logic [2:0] test_sel;
    logic sda_line;
    int checks = 0, fails = 0, r12_bad = 0;
    logic oe_prev = 1'b0;

    assign sda_line = sda_m & ~sda_oe;
    always #10 clk = ~clk;            // 50 MHz

    tuner_i2c_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .addr_sel(addr_sel), .lock_in(lock_in), .adc_code(adc_code),
        .sda_oe(sda_oe), .div_word(div_word), .presc_en(presc_en),
        .ref_div_sel(ref_div_sel), .cp_cur(cp_cur), .ref_out_en(ref_out_en),
        .ref_out_cmp(ref_out_cmp), .port_out(port_out), .port_hiz(port_hiz),
        .test_sel(test_sel)
    );

    // R12 monitor: the SDA enable must not change while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl_m) r12_bad++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(2);
        sda_m = 1'b0; wq(2);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wq(1); sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(2);
    endtask

    task automatic put_bit(input logic b);
        wq(1); sda_m = b; wq(1);
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] d, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        wq(1); sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        acked = ~sda_line;
        wq(1); scl_m = 1'b0;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            wq(2); scl_m = 1'b1; wq(1);
            d = {d[6:0], sda_line};
            wq(1); scl_m = 1'b0;
        end
        wq(1); sda_m = give_ack ? 1'b0 : 1'b1; wq(1);
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0;
        @(negedge clk); sda_m = 1'b1;
    endtask

    task automatic t_reset();
        chk("R11 div", div_word, 0);
        chk("R11 presc", presc_en, 0);
        chk("R11 refsel", ref_div_sel, 0);
        chk("R11 cp", cp_cur, 0);
        chk("R11 ref_en", ref_out_en, 1);
        chk("R11 ref_cmp", ref_out_cmp, 1);
        chk("R11 ports", port_out, 0);
        chk("R11 test_sel", test_sel, 0);
        chk("R9 hiz at power-up", port_hiz, 1);
        chk("R11 sda idle", sda_oe, 0);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        put_byte(BADADDR, a); chk("R1 no ack wrong addr", a, 0);
        put_byte(8'h81, a);   chk("R1 ignored byte no ack", a, 0);
        bus_stop();
        chk("R1 refsel untouched", ref_div_sel, 0);
        chk("R1 div untouched", div_word, 0);
    endtask

    task automatic t_freq_only();
        logic a;
        bus_start();
        put_byte(WADDR, a); chk("R1 addr ack", a, 1);
        put_byte(8'h12, a); chk("R2 data ack", a, 1);
        put_byte(8'h34, a); chk("R2 data ack", a, 1);
        put_byte(8'h05, a);
        put_byte(8'h67, a);
        chk("R5 freq pairs no commit", div_word, 0);
        bus_stop();
        chk("R5 R6 commit at stop", div_word, 17'h00567);
    endtask

    task automatic t_full_word();
        logic a;
        bus_start();
        put_byte(WADDR, a);
        put_byte(8'h2A, a);
        put_byte(8'hBC, a);
        put_byte(8'hD5, a);
        chk("R5 commit on 17 bits", div_word, 17'h12ABC);
        chk("R4 presc", presc_en, 1);
        chk("R4 refsel", ref_div_sel, 4'h5);
        put_byte(8'h6B, a);
        chk("R4 cp", cp_cur, 2'b01);
        chk("R4 ref_en", ref_out_en, 1);
        chk("R4 ref_cmp", ref_out_cmp, 0);
        chk("R4 ports", port_out, 4'hB);
        bus_stop();
    endtask

    task automatic t_ctrl_first_test();
        logic a;
        bus_start();
        put_byte(WADDR, a);
        put_byte(8'h83, a);
        chk("R4 R6 refsel ctrl first", ref_div_sel, 4'h3);
        chk("R4 presc cleared", presc_en, 0);
        put_byte(8'h9C, a);
        chk("R10 test_sel", test_sel, 3'b100);
        chk("R10 ports low held", port_out, 4'hB);
        chk("R10 cp", cp_cur, 2'b10);
        put_byte(8'h01, a);
        put_byte(8'h02, a);
        chk("R3 R6 commit after ctrl pair", div_word, 17'h00102);
        bus_stop();
    endtask

    task automatic t_stop_mid_byte();
        logic a;
        bus_start();
        put_byte(WADDR, a);
        put_byte(8'h7F, a);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        chk("R7 partial dropped, hi kept", div_word, 17'h07F02);
        chk("R7 refsel kept", ref_div_sel, 4'h3);
        chk("R7 presc kept", presc_en, 0);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] d;
        lock_in = 1'b1; adc_code = 3'b101;
        bus_start();
        put_byte(RADDR, a); chk("R1 read addr ack", a, 1);
        get_byte(1'b1, d);  chk("R8 status 1", d, 8'hC5);
        lock_in = 1'b0; adc_code = 3'b010;
        get_byte(1'b0, d);  chk("R8 status refreshed", d, 8'h82);
        get_byte(1'b0, d);  chk("R8 released after nack", d, 8'hFF);
        chk("R9 hiz before stop", port_hiz, 1);
        bus_stop();
        chk("R9 por cleared", port_hiz, 0);
        bus_start();
        put_byte(RADDR, a);
        get_byte(1'b0, d);  chk("R9 R8 status por low", d, 8'h02);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_wrong_addr();
        t_freq_only();
        t_full_word();
        t_ctrl_first_test();
        t_stop_mid_byte();
        t_read();
        chk("R12 sda changes in scl low", r12_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule